// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

A single timer channel with a small word-addressed register file. A 32-bit live count falls by one on every prescaled tick of the system clock. When a tick arrives while the count is already zero, the count reloads from a programmable reload value and an underflow flag is latched. The prescaler divides the clock by 4, 16, 64, 256 or 1024, as selected by a three-bit code in the control word.

An external `run` input gates counting. While `run` is low the prescaler and the count both hold. Any write to the control word pauses the prescaler for that cycle and clears its accumulator, so counting resumes with the new divisor from a clean period. The underflow flag drives `irq` when the interrupt-enable bit is set. Software can clear the flag but cannot set it.

A capture word is provided as plain storage when the channel is built with `HAS_CAPTURE`. No capture sampling or external-clock counting is done.

Top module: `reload_timer`

## Requirements
- R1: After reset, the reload word and the count both read 0xFFFFFFFF, the control word reads 0 and `irq` is 0.
- R2: `reg_sel` chooses the word: 0 is reload, 1 is count, 2 is control, 3 is capture. A write stores `wdata`. A read returns the word on the next cycle. The count read is the live value, and the capture word reads back only when `HAS_CAPTURE` is 1 (otherwise it reads 0).
- R3: Control bits 2:0 select a divisor of 4 << (2*code) for codes 0 to 4. Ticks occur only while `run` is high.
- R4: Each tick decrements a non-zero count by one. A tick on a zero count loads the reload word in the same cycle (underflow).
- R5: An underflow sets the flag, which reads back in control bit 8. Because ticks need `run`, the flag can only be set while the channel is running.
- R6: A control write with bit 8 equal to 0 clears the flag. A control write with bit 8 equal to 1 leaves it unchanged.
- R7: `irq` equals the flag ANDed with control bit 5 (interrupt enable), updated in the same cycle as the flag.
- R8: A control write resets the prescaler, so the first tick after it comes a full divisor period later.
- R9: Control bits 15:9 always read 0. Bits 4:3 read 0 unless `HAS_EXTCLK` is set. Bits 7:6 read 0 unless `HAS_CAPTURE` is set.
- R10: Prescaler codes 5, 6 and 7 produce no ticks, so the count holds.
- R11: A count write loads the count directly and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start gate; counting happens only while high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Word select (byte offset bits 3:2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Underflow interrupt |

## Verification
The hardest case to reach is a count write or a control write that falls on the exact cycle where the prescaler would have ticked. It can only be hit by counting clock edges from the last control write, because that write is the only event that sets the prescaler phase. The bench times each directed scenario from a control write. It then places a count write on the fourth edge after it, and a second control write three edges after a first one. Reading the count back separates a loaded value from a decremented one, and separates a restarted period from a continued one.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  localparam logic [1:0] SEL_RELOAD  = 2'd0;
  localparam logic [1:0] SEL_COUNT   = 2'd1;
  localparam logic [1:0] SEL_CTRL    = 2'd2;
  localparam logic [1:0] SEL_CAPTURE = 2'd3;

  localparam int CTRL_W   = 16;
  localparam int IE_BIT   = 5;
  localparam int FLAG_BIT = 8;
  localparam int MAX_CODE = 4;

  // Terminal value of the prescaler accumulator for a given code.
  function automatic logic [31:0] psc_limit(input logic [2:0] code);
    return (32'd4 << (2 * code)) - 32'd1;
  endfunction

  function automatic logic psc_valid(input logic [2:0] code);
    return (int'(code) <= MAX_CODE);
  endfunction
endpackage

// File: rtl/rtm_prescaler.sv
module rtm_prescaler #(
  parameter int DIV_LOG2_MAX = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] code,
  output logic       tick
);
  import rtm_pkg::*;
  localparam int ACC_W = DIV_LOG2_MAX;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] lim;
  logic             active;
  logic [31:0]      lim_full;

  always_comb begin
    lim_full = psc_limit(code);
    lim      = lim_full[ACC_W-1:0];
    active   = run && !restart && psc_valid(code);
    tick     = active && (acc == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc <= '0;
    end else if (active) begin
      if (acc == lim) acc <= '0;
      else            acc <= acc + 1'b1;
    end
  end
endmodule

// File: rtl/rtm_counter.sv
module rtm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);
  assign underflow = tick && !load && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '1;
    end else if (load) begin
      count <= load_val;
    end else if (tick) begin
      if (count == '0) count <= reload_val;
      else             count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rtm_regs.sv
module rtm_regs #(
  parameter int          CNT_W       = 32,
  parameter bit          HAS_CAPTURE = 1'b1,
  parameter bit          HAS_EXTCLK  = 1'b0,
  parameter logic [31:0] CAP_INIT    = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             underflow,
  output logic [31:0]      rdata,
  output logic [CNT_W-1:0] reload_val,
  output logic             cnt_wr,
  output logic             ctrl_wr,
  output logic [2:0]       psc_code,
  output logic             flag,
  output logic             ie,
  output logic             irq
);
  import rtm_pkg::*;

  localparam logic [CTRL_W-1:0] BASE_MASK = 16'h0027;
  localparam logic [CTRL_W-1:0] EXT_MASK  = HAS_EXTCLK  ? 16'h0018 : 16'h0000;
  localparam logic [CTRL_W-1:0] CAP_MASK  = HAS_CAPTURE ? 16'h00C0 : 16'h0000;
  localparam logic [CTRL_W-1:0] WMASK     = BASE_MASK | EXT_MASK | CAP_MASK;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d, ctrl_rb;
  logic              flag_d;
  logic [31:0]       cap_rb;
  logic [31:0]       cnt_rb, rel_rb;

  assign cnt_wr  = wr_en && (reg_sel == SEL_COUNT);
  assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);

  always_comb begin
    ctrl_d = ctrl_wr ? (wdata[CTRL_W-1:0] & WMASK) : ctrl_q;
    flag_d = flag;
    if (underflow)                      flag_d = 1'b1;
    else if (ctrl_wr && !wdata[FLAG_BIT]) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      flag       <= 1'b0;
      irq        <= 1'b0;
      reload_val <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      flag   <= flag_d;
      irq    <= flag_d && ctrl_d[IE_BIT];
      if (wr_en && (reg_sel == SEL_RELOAD)) reload_val <= wdata[CNT_W-1:0];
    end
  end

  generate
    if (HAS_CAPTURE) begin : g_cap
      logic [31:0] cap_q;
      always_ff @(posedge clk) begin
        if (rst)                                  cap_q <= CAP_INIT;
        else if (wr_en && (reg_sel == SEL_CAPTURE)) cap_q <= wdata;
      end
      assign cap_rb = cap_q;
    end else begin : g_nocap
      assign cap_rb = 32'h0;
    end
  endgenerate

  assign psc_code = ctrl_q[2:0];
  assign ie       = ctrl_q[IE_BIT];
  assign ctrl_rb  = {ctrl_q[CTRL_W-1:FLAG_BIT+1], flag, ctrl_q[FLAG_BIT-1:0]};
  assign cnt_rb   = 32'(count);
  assign rel_rb   = 32'(reload_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (reg_sel)
        SEL_RELOAD: rdata <= rel_rb;
        SEL_COUNT:  rdata <= cnt_rb;
        SEL_CTRL:   rdata <= {{(32-CTRL_W){1'b0}}, ctrl_rb};
        default:    rdata <= cap_rb;
      endcase
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int          CNT_W        = 32,
  parameter int          DIV_LOG2_MAX = 10,
  parameter bit          HAS_CAPTURE  = 1'b1,
  parameter bit          HAS_EXTCLK   = 1'b0,
  parameter logic [31:0] CAP_INIT     = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  logic             tick, underflow, cnt_wr, ctrl_wr, flag, ie;
  logic [2:0]       psc_code;
  logic [CNT_W-1:0] count, reload_val;

  rtm_prescaler #(.DIV_LOG2_MAX(DIV_LOG2_MAX)) u_psc (
    .clk(clk), .rst(rst), .run(run), .restart(ctrl_wr),
    .code(psc_code), .tick(tick)
  );

  rtm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_wr),
    .load_val(wdata[CNT_W-1:0]), .reload_val(reload_val),
    .count(count), .underflow(underflow)
  );

  rtm_regs #(
    .CNT_W(CNT_W), .HAS_CAPTURE(HAS_CAPTURE),
    .HAS_EXTCLK(HAS_EXTCLK), .CAP_INIT(CAP_INIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wdata(wdata), .count(count), .underflow(underflow), .rdata(rdata),
    .reload_val(reload_val), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
    .psc_code(psc_code), .flag(flag), .ie(ie), .irq(irq)
  );
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             rd_en,
  input logic [1:0]       reg_sel,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             irq,
  input logic             tick,
  input logic             cnt_wr,
  input logic             ctrl_wr,
  input logic             flag,
  input logic             ie,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_val
);
  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ie)); // R7
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick); // R3
  AST_NO_TICK_ON_CTRL_WR: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |-> !tick); // R8
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && count != '0) |=> count == $past(count) - CNT_W'(1)); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && count == '0) |=> count == $past(reload_val)); // R4
  AST_FLAG_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && count == '0) |=> flag); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wdata[8]) |=> !flag); // R6
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> count == $past(wdata[CNT_W-1:0])); // R11
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == 2'd2) |=> rdata[15:9] == 7'd0); // R9
endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .rd_en(rd_en), .reg_sel(reg_sel),
  .wdata(wdata), .rdata(rdata), .irq(irq), .tick(tick), .cnt_wr(cnt_wr),
  .ctrl_wr(ctrl_wr), .flag(flag), .ie(ie), .count(count),
  .reload_val(reload_val)
);

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  reload_timer dut (
    .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_sel = sel; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(2'd0, v); check("R1 reload", v, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R1 count", v, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R1 ctrl", v, 32'h0);
  endtask

  task automatic t_underflow_div4();
    logic [31:0] v;
    wr(2'd0, 32'h20);
    wr(2'd1, 32'd2);
    run = 1'b1;
    wr(2'd2, 32'h020);
    idle(11);
    check("R4 no underflow before third tick", {31'd0, irq}, 32'd0);
    idle(1);
    check("R7 irq on underflow", {31'd0, irq}, 32'd1);
    rd(2'd1, v); check("R4 reload after underflow", v, 32'h20);
    rd(2'd2, v); check("R5 flag readback", v, 32'h120);
    run = 1'b0;
  endtask

  task automatic t_flag_clear();
    logic [31:0] v;
    wr(2'd2, 32'h120);
    check("R6 write one keeps flag irq", {31'd0, irq}, 32'd1);
    rd(2'd2, v); check("R6 write one keeps flag", v, 32'h120);
    wr(2'd2, 32'h020);
    check("R6 write zero clears irq", {31'd0, irq}, 32'd0);
    rd(2'd2, v); check("R6 write zero clears flag", v, 32'h020);
  endtask

  task automatic t_ie_off();
    logic [31:0] v;
    wr(2'd1, 32'd0);
    run = 1'b1;
    wr(2'd2, 32'h100);
    idle(6);
    run = 1'b0;
    check("R7 irq masked", {31'd0, irq}, 32'd0);
    rd(2'd2, v); check("R5 flag set with ie off", v, 32'h100);
    wr(2'd2, 32'h000);
  endtask

  task automatic t_run_low();
    logic [31:0] v;
    run = 1'b0;
    wr(2'd1, 32'd7);
    wr(2'd2, 32'h020);
    idle(20);
    rd(2'd1, v); check("R3 count holds while run low", v, 32'd7);
    check("R5 no flag while run low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_div16();
    logic [31:0] v;
    wr(2'd0, 32'd5);
    wr(2'd1, 32'd0);
    run = 1'b1;
    wr(2'd2, 32'h021);
    idle(15);
    check("R3 div16 no tick before 16", {31'd0, irq}, 32'd0);
    idle(1);
    check("R3 div16 tick at 16", {31'd0, irq}, 32'd1);
    run = 1'b0;
    rd(2'd1, v); check("R4 reload value 5", v, 32'd5);
    wr(2'd2, 32'h000);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(2'd1, 32'd10);
    run = 1'b1;
    wr(2'd2, 32'h000);
    idle(2);
    wr(2'd2, 32'h000);
    idle(3);
    rd(2'd1, v); check("R8 no tick within new period", v, 32'd10);
    rd(2'd1, v); check("R8 tick one full period after write", v, 32'd9);
    run = 1'b0;
  endtask

  task automatic t_reserved_bits();
    logic [31:0] v;
    wr(2'd2, 32'h0000_FFFF);
    rd(2'd2, v); check("R9 reserved bits read zero", v, 32'h0000_00E7);
    wr(2'd2, 32'h000);
  endtask

  task automatic t_bad_code();
    logic [31:0] v;
    wr(2'd1, 32'd3);
    run = 1'b1;
    wr(2'd2, 32'h005);
    idle(40);
    rd(2'd1, v); check("R10 code 5 no ticks", v, 32'd3);
    wr(2'd2, 32'h007);
    idle(40);
    rd(2'd1, v); check("R10 code 7 no ticks", v, 32'd3);
    run = 1'b0;
    wr(2'd2, 32'h000);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(2'd3, 32'h1234_5678);
    rd(2'd3, v); check("R2 capture storage", v, 32'h1234_5678);
    wr(2'd0, 32'hA5A5_0001);
    rd(2'd0, v); check("R2 reload readback", v, 32'hA5A5_0001);
  endtask

  task automatic t_load_on_tick();
    logic [31:0] v;
    wr(2'd1, 32'h40);
    run = 1'b1;
    wr(2'd2, 32'h000);
    idle(3);
    wr(2'd1, 32'h55);
    rd(2'd1, v); check("R11 count write beats tick", v, 32'h55);
    run = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_underflow_div4();
    t_flag_clear();
    t_ie_off();
    t_run_low();
    t_div16();
    t_restart();
    t_reserved_bits();
    t_bad_code();
    t_regmap();
    t_load_on_tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule